// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers six asynchronous interrupt sources into one host interrupt. Each source first passes through a synchroniser. A rising edge on a source whose enable bit is set then marks a sticky bit in a status word, and the host reads that word directly. The host sees a one-cycle interrupt pulse when the status word leaves the all-zero state. A level output stays high for as long as any status bit is set.

No clear register exists. The host clears a status bit by writing its enable bit to 0. Writing the bit back to 1 re-arms the source for the next rising edge. No further pulse is produced while the status word stays nonzero. A new pulse needs the word to return to zero and then a fresh enabled edge.

Top module: `irq_edge_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, status_o, irq_pulse_o and irq_level_o are 0 and every enable bit is 0, until a write and a source edge occur.
- R2: A 0-to-1 change on src_in[i] sets status_o[i] if enable bit i is 1. The change is driven between clock edges, and the bit is visible after the third rising clock edge that follows the change.
- R3: A set status bit stays 1 when its source returns to 0 or toggles again.
- R4: A rising edge on a source whose enable bit is 0 has no effect: its status bit stays 0 and no pulse appears.
- R5: A write with mask_we=1 loads mask_wdata into the enable register. From the next clock edge, every status bit whose new enable bit is 0 reads 0. Status bits whose enable stays 1 are unchanged.
- R6: When the status word changes from zero to nonzero, irq_pulse_o is high for exactly one cycle. It rises one clock edge after the status word first reads nonzero.
- R7: No further pulse occurs while the status word stays nonzero, even when more bits become set. After the word returns to zero, the next enabled edge produces a new pulse.
- R8: irq_level_o is 1 from the cycle in which the pulse is high until one cycle after the status word returns to zero.
- R9: If a source's edge is detected in the same cycle as a write that clears its enable bit, the disable wins and the status bit stays 0.
- R10: Status bits are set by edges, not by levels. A source held high while it is re-enabled does not set its bit.
- R11: Status bit i is driven only by src_in[i] and enable bit i. Bit 0 of mask_wdata enables src_in[0], and so on up to bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mask_we | input | 1 | Enable-register write strobe |
| mask_wdata | input | 6 | New enable mask, one bit per source |
| src_in | input | 6 | Asynchronous interrupt source lines |
| status_o | output | 6 | Latched status word, one bit per source |
| irq_pulse_o | output | 1 | One-cycle host interrupt on the zero-to-nonzero transition |
| irq_level_o | output | 1 | High while the status word is nonzero (delayed one cycle) |

## Verification
A corrupted enable register shows up at status_o within three edges of the next source edge: an edge is either wrongly latched or wrongly dropped. A corrupted status bit appears on status_o at once, and on irq_level_o one cycle later. A wrong zero-detect history in the notification stage shows as a missing or extra pulse. The bench counts pulses across each scenario to catch this, and it holds the same-cycle disable and edge collision to an exact clock edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned IRQ_SRC_COUNT   = 6;
  parameter int unsigned IRQ_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int unsigned SYNC_STAGES = irq_agg_pkg::IRQ_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  output logic rise_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] samp_q;
  logic [DEPTH-1:0] samp_d;

  always_comb begin
    samp_d = {samp_q[DEPTH-2:0], src_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= samp_d;
  end

  assign rise_o = samp_q[SYNC_STAGES-1] & ~samp_q[SYNC_STAGES];
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NSRC = irq_agg_pkg::IRQ_SRC_COUNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise_i,
  input  logic            we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] status_o
);
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] stat_q, stat_d;

  always_comb begin
    en_d = we_i ? wdata_i : en_q;
    // a disable in the same cycle as an edge clears the bit
    stat_d = (stat_q | (rise_i & en_q)) & en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (we_i) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status_o = stat_q;

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0)); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((stat_q & ~$past(wdata_i)) == '0)); // R5
  AST_STICKY_WHILE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ((~stat_q & $past(stat_q)) == '0)); // R3
endmodule

// File: rtl/irq_notify.sv
module irq_notify #(
  parameter int unsigned NSRC = irq_agg_pkg::IRQ_SRC_COUNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status_i,
  output logic            pulse_o,
  output logic            level_o
);
  logic any_set;
  logic nz_q, nz_d;
  logic pulse_q, pulse_d;

  always_comb begin
    any_set = |status_i;
    nz_d    = any_set;
    pulse_d = any_set & ~nz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      nz_q    <= nz_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
  assign level_o = nz_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R6
  AST_LEVEL_RISE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nz_q) |-> pulse_q); // R6
  AST_PULSE_ONLY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !$past(nz_q)); // R7
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i != '0) |=> level_o); // R8
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl #(
  parameter int unsigned NSRC        = irq_agg_pkg::IRQ_SRC_COUNT,
  parameter int unsigned SYNC_STAGES = irq_agg_pkg::IRQ_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic [NSRC-1:0] src_in,
  output logic [NSRC-1:0] status_o,
  output logic            irq_pulse_o,
  output logic            irq_level_o
);
  logic            rst_sn;
  logic [NSRC-1:0] rise;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sn)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_sn), .src_i(src_in[i]), .rise_o(rise[i])
    );
  end

  irq_status_reg #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_sn), .rise_i(rise), .we_i(mask_we),
    .wdata_i(mask_wdata), .status_o(status_o)
  );

  irq_notify #(.NSRC(NSRC)) u_ntf (
    .clk(clk), .rst_n(rst_sn), .status_i(status_o),
    .pulse_o(irq_pulse_o), .level_o(irq_level_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sn |=> (status_o == '0 && !irq_pulse_o)); // R1
endmodule

// File: tb/tb_irq_edge_ctrl.sv
`timescale 1ns/1ps
module tb_irq_edge_ctrl;
  localparam int N = 6;
  logic clk = 1'b0;
  logic rst_n;
  logic mask_we;
  logic [N-1:0] mask_wdata, src_in, status_o;
  logic irq_pulse_o, irq_level_o;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .src_in(src_in), .status_o(status_o), .irq_pulse_o(irq_pulse_o),
    .irq_level_o(irq_level_o)
  );

  always @(negedge clk) if (irq_pulse_o) pulses++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_wdata = m;
    tick(1);
    mask_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mask_we = 1'b0; mask_wdata = '0; src_in = '0;
    tick(3);
    chk("R1 status in reset", 32'(status_o), 0);
    chk("R1 pulse in reset", 32'(irq_pulse_o), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 status after reset", 32'(status_o), 0);
    chk("R1 level after reset", 32'(irq_level_o), 0);
    // enables are 0 after reset: an edge must not latch
    src_in[3] = 1'b1; tick(5);
    chk("R1 enables zero", 32'(status_o), 0);
    src_in[3] = 1'b0; tick(4);
  endtask

  task automatic t_basic;
    int p0;
    wr_mask(6'b000100);
    p0 = pulses;
    src_in[2] = 1'b1;
    tick(2);
    chk("R2 not yet set", 32'(status_o), 0);
    tick(1);
    chk("R2 R11 bit2 set", 32'(status_o), 32'h04);
    chk("R6 pulse not yet", 32'(irq_pulse_o), 0);
    tick(1);
    chk("R6 pulse high", 32'(irq_pulse_o), 1);
    chk("R8 level high", 32'(irq_level_o), 1);
    tick(1);
    chk("R6 pulse one cycle", 32'(irq_pulse_o), 0);
    src_in[2] = 1'b0; tick(3); src_in[2] = 1'b1; tick(3); src_in[2] = 1'b0; tick(4);
    chk("R3 sticky", 32'(status_o), 32'h04);
    chk("R7 single pulse", 32'(pulses - p0), 1);
    wr_mask(6'b000000);
    chk("R5 cleared", 32'(status_o), 0);
    chk("R8 level lags", 32'(irq_level_o), 1);
    tick(1);
    chk("R8 level low", 32'(irq_level_o), 0);
  endtask

  task automatic t_disabled;
    int p0;
    wr_mask(6'b000001);
    p0 = pulses;
    src_in[4] = 1'b1; tick(6);
    chk("R4 disabled ignored", 32'(status_o), 0);
    chk("R4 no pulse", 32'(pulses - p0), 0);
    src_in[4] = 1'b0; tick(4);
    wr_mask(6'b000000);
  endtask

  task automatic t_multi;
    int p0;
    wr_mask(6'b100011);
    p0 = pulses;
    src_in[0] = 1'b1; tick(6);
    src_in[1] = 1'b1; tick(6);
    chk("R11 two bits", 32'(status_o), 32'h03);
    chk("R7 no second pulse", 32'(pulses - p0), 1);
    wr_mask(6'b100010);
    chk("R5 others kept", 32'(status_o), 32'h02);
    wr_mask(6'b100000);
    tick(2);
    chk("R8 level drops", 32'(irq_level_o), 0);
    src_in[5] = 1'b1; tick(6);
    chk("R7 re-armed status", 32'(status_o), 32'h20);
    chk("R7 new pulse", 32'(pulses - p0), 2);
    wr_mask(6'b000000);
    src_in = '0; tick(4);
  endtask

  task automatic t_collide;
    int p0;
    wr_mask(6'b001000);
    p0 = pulses;
    src_in[3] = 1'b1;
    tick(2);
    mask_we = 1'b1; mask_wdata = 6'b000000;
    tick(1);
    mask_we = 1'b0;
    tick(4);
    chk("R9 disable wins", 32'(status_o), 0);
    chk("R9 no pulse", 32'(pulses - p0), 0);
    wr_mask(6'b001000);
    tick(6);
    chk("R10 level not edge", 32'(status_o), 0);
    src_in[3] = 1'b0; tick(3); src_in[3] = 1'b1; tick(3);
    chk("R10 fresh edge sets", 32'(status_o), 32'h08);
    wr_mask(6'b000000);
    src_in = '0; tick(4);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_disabled();
    t_multi();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule